// File: doc/BRIEF.md
# Pipelined Saturating Multiply-Accumulate Unit

This block is a fixed-point multiply-accumulate engine for signed two's-complement operands of `DW` bits. A first pipeline stage forms the full-precision product of two operands. A second stage adds that product to, or subtracts it from, an accumulator. The accumulator carries `GW` guard bits above the `2*DW` product width. Because the two stages overlap, a series of N back-to-back operations completes N+1 cycles after the first operand pair is accepted.

Each operand pair carries its own add/subtract select and saturation enable. With saturation on, an overflow of the `2*DW`-bit range is detected from the carries around the top product bit, and the accumulator is loaded with the extreme value of the matching sign. A sticky flag records every clamp until the accumulator is cleared. A combinational output stage drops the duplicated sign bit of the accumulated value and returns a `DW`-bit result, either truncated or rounded, and clamped when the accumulator holds more than that result can represent.

Top module: `mac_sat_unit`

## Requirements
- R1: When `in_vld` is high, the pair `op_a`, `op_b` is multiplied as signed values. The exact `2*DW`-bit product enters the accumulator, so after a clear and a single add, `{ext_o, acc_o}` equals the signed product.
- R2: `sub_sel`, sampled with the operands, makes the accumulator subtract the product instead of adding it. Without an operation or a clear, the accumulator holds its value.
- R3: A high `clr` sampled at a clock edge sets the accumulator, `ovf_o` and `acc_vld_o` to zero. It takes priority over a product that reaches the accumulate stage on the same edge, and that product is discarded.
- R4: An operation sampled at edge k updates the accumulator at edge k+1, and `acc_vld_o` is high for the cycle that follows each update. N back-to-back operations whose first is driven in cycle C finish their last update at edge C+N+1.
- R5: With saturation off, the accumulator is `2*DW+GW` bits wide and wraps only at that width. `ext_o` shows the `GW` bits above `acc_o`.
- R6: With saturation on, if the carry into bit `2*DW-1` differs from the carry out of it and the carry in is 1, the accumulator is loaded with 2^(2*DW-1)-1, and its guard bits are zero.
- R7: In the same case with a carry in of 0, the accumulator is loaded with -2^(2*DW-1), and its guard bits are all ones.
- R8: `ovf_o` goes high after any clamp of R6 or R7 and stays high until a clear. Operations without a clamp do not set it.
- R9: With `rnd_en` low and the accumulator within ±2^(2*DW-2), `res_o` is accumulator bits `2*DW-2` down to `DW-1`. This is the value shifted left by one with the upper `DW` bits kept.
- R10: With `rnd_en` high, accumulator bit `DW-2` is added to the R9 result. A result already at 2^(DW-1)-1 stays there instead of wrapping.
- R11: When the accumulator is at or above 2^(2*DW-2), `res_o` is 2^(DW-1)-1. When it is below -2^(2*DW-2), `res_o` is -2^(DW-1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Operand pair valid |
| op_a | input | DW | Signed operand A |
| op_b | input | DW | Signed operand B |
| sub_sel | input | 1 | 1 subtracts the product, 0 adds it |
| sat_en | input | 1 | Saturation enable for this operation |
| clr | input | 1 | Clears accumulator and overflow flag |
| rnd_en | input | 1 | 1 rounds the result, 0 truncates it |
| res_o | output | DW | Sign-bit-dropped, rounded or truncated result |
| acc_o | output | 2*DW | Low product-width bits of the accumulator |
| ext_o | output | GW | Guard bits of the accumulator |
| acc_vld_o | output | 1 | High the cycle after an accumulator update |
| ovf_o | output | 1 | Sticky saturation flag |

## Verification
The assertions assume that `sat_en` stays high for every operation of a series that relies on the clamped range. If it were dropped partway through, the guard bits could carry growth that the next saturating operation ignores. They also assume that `clr` is used only between series or to cancel an operation deliberately. The stimulus keeps saturation fixed within each series and issues a clear before each new one. Overlap of a clear with an in-flight product is driven only in the single directed case that checks clear priority.

// File: rtl/macs_pkg.sv
package macs_pkg;

    // Outcome of the carry comparison at the product-width sign bit.
    typedef enum logic [1:0] {
        SAT_NONE = 2'd0,
        SAT_POS  = 2'd1,
        SAT_NEG  = 2'd2
    } sat_kind_e;

    // Carries into and out of the top bit disagree: the sum left the range.
    // A carry in of 1 with no carry out means two positives overflowed.
    function automatic sat_kind_e classify_carry(input logic c_in_msb, input logic c_out_msb);
        if (c_in_msb == c_out_msb) begin
            return SAT_NONE;
        end
        return c_in_msb ? SAT_POS : SAT_NEG;
    endfunction

endpackage

// File: rtl/mac_mul_stage.sv
module mac_mul_stage #(
    parameter int unsigned DW = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                vld_i,
    input  logic [DW-1:0]       a_i,
    input  logic [DW-1:0]       b_i,
    input  logic                sub_i,
    input  logic                sat_i,
    output logic                vld_o,
    output logic [2*DW-1:0]     prod_o,
    output logic                sub_o,
    output logic                sat_o
);
    localparam int unsigned PW = 2 * DW;

    logic [PW-1:0] a_ext;
    logic [PW-1:0] b_ext;
    logic [PW-1:0] prod_d;

    // Sign-extended operands: the low PW bits of the product are exact.
    always_comb begin
        a_ext  = {{DW{a_i[DW-1]}}, a_i};
        b_ext  = {{DW{b_i[DW-1]}}, b_i};
        prod_d = a_ext * b_ext;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o  <= 1'b0;
            prod_o <= '0;
            sub_o  <= 1'b0;
            sat_o  <= 1'b0;
        end else begin
            vld_o <= vld_i;
            if (vld_i) begin
                prod_o <= prod_d;
                sub_o  <= sub_i;
                sat_o  <= sat_i;
            end
        end
    end

    // R4: an accepted pair is always handed to the accumulate stage next cycle
    p_vld_track_r4: assert property (@(posedge clk) disable iff (rst)
        vld_i |=> vld_o);

    // R4: no operation appears in stage two without an input strobe
    p_vld_idle_r4: assert property (@(posedge clk) disable iff (rst)
        !vld_i |=> !vld_o);

endmodule

// File: rtl/mac_acc_stage.sv
module mac_acc_stage
    import macs_pkg::*;
#(
    parameter int unsigned DW = 16,
    parameter int unsigned GW = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    upd_i,
    input  logic                    sub_i,
    input  logic                    sat_i,
    input  logic                    clr_i,
    input  logic [2*DW-1:0]         prod_i,
    output logic [2*DW+GW-1:0]      acc_o,
    output logic                    upd_o,
    output logic                    ovf_o
);
    localparam int unsigned PW = 2 * DW;
    localparam int unsigned AW = PW + GW;

    logic [AW-1:0] acc_q;
    logic [AW-1:0] prod_ext;
    logic [AW-1:0] wrap_sum;
    logic [PW-1:0] opnd;
    logic [PW:0]   full;
    logic          c_in_msb;
    sat_kind_e     kind;
    logic [AW-1:0] sat_sum;
    logic [AW-1:0] next_acc;
    logic          upd_q;
    logic          ovf_q;

    always_comb begin
        // Guard-bit path: full-width add/sub, wraps only at AW.
        prod_ext = {{GW{prod_i[PW-1]}}, prod_i};
        wrap_sum = sub_i ? (acc_q - prod_ext) : (acc_q + prod_ext);

        // Saturating path: PW-bit add of acc and (possibly inverted) product.
        opnd     = sub_i ? ~prod_i : prod_i;
        full     = {1'b0, acc_q[PW-1:0]} + {1'b0, opnd} + {{PW{1'b0}}, sub_i};
        c_in_msb = full[PW-1] ^ acc_q[PW-1] ^ opnd[PW-1];
        kind     = classify_carry(c_in_msb, full[PW]);

        unique case (kind)
            SAT_POS: sat_sum = {{(GW+1){1'b0}}, {(PW-1){1'b1}}};
            SAT_NEG: sat_sum = {{(GW+1){1'b1}}, {(PW-1){1'b0}}};
            default: sat_sum = {{GW{full[PW-1]}}, full[PW-1:0]};
        endcase

        next_acc = sat_i ? sat_sum : wrap_sum;
    end

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            acc_q <= '0;
            upd_q <= 1'b0;
            ovf_q <= 1'b0;
        end else begin
            upd_q <= upd_i;
            if (upd_i) begin
                acc_q <= next_acc;
                if (sat_i && (kind != SAT_NONE)) begin
                    ovf_q <= 1'b1;
                end
            end
        end
    end

    assign acc_o = acc_q;
    assign upd_o = upd_q;
    assign ovf_o = ovf_q;

    // R3: a clear wins over everything on the same edge
    p_clear_zero_r3: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (acc_q == '0 && !ovf_q && !upd_q));

    // R2: the accumulator is quiet between operations
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!upd_i && !clr_i) |=> $stable(acc_q));

    // R6: a saturating update leaves guard bits as pure sign copies
    p_guard_signext_r6: assert property (@(posedge clk) disable iff (rst)
        (upd_i && sat_i && !clr_i) |=>
            (acc_q[AW-1:PW-1] == '0 || acc_q[AW-1:PW-1] == '1));

    // R8: the overflow flag is sticky until a clear
    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (ovf_q && !clr_i) |=> ovf_q);

    // R8: the flag only rises with a saturating update in flight
    p_ovf_cause_r8: assert property (@(posedge clk) disable iff (rst)
        (!ovf_q && !(upd_i && sat_i)) |=> !ovf_q);

endmodule

// File: rtl/mac_out_stage.sv
module mac_out_stage #(
    parameter int unsigned DW = 16,
    parameter int unsigned GW = 8
) (
    // Accumulator bits AW-1 down to DW-2; the lower bits never reach the result.
    input  logic [GW+DW+1:0]    hi_i,
    input  logic                rnd_i,
    output logic [DW-1:0]       res_o
);
    localparam int unsigned HW   = GW + DW + 2;
    localparam int unsigned TOPW = GW + 2;
    localparam logic [DW-1:0] MAX_RES = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] MIN_RES = {1'b1, {(DW-1){1'b0}}};

    logic [TOPW-1:0] top;
    logic            in_range;
    logic [DW-1:0]   slice;
    logic            rbit;

    always_comb begin
        top      = hi_i[HW-1:DW];
        in_range = (&top) | ~(|top);
        slice    = hi_i[DW:1];
        rbit     = hi_i[0];

        if (!in_range) begin
            res_o = hi_i[HW-1] ? MIN_RES : MAX_RES;
        end else if (rnd_i && rbit && (slice != MAX_RES)) begin
            res_o = slice + {{(DW-1){1'b0}}, 1'b1};
        end else begin
            res_o = slice;
        end
    end

endmodule

// File: rtl/mac_sat_unit.sv
module mac_sat_unit
    import macs_pkg::*;
#(
    parameter int unsigned DW = 16,
    parameter int unsigned GW = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_vld,
    input  logic [DW-1:0]       op_a,
    input  logic [DW-1:0]       op_b,
    input  logic                sub_sel,
    input  logic                sat_en,
    input  logic                clr,
    input  logic                rnd_en,
    output logic [DW-1:0]       res_o,
    output logic [2*DW-1:0]     acc_o,
    output logic [GW-1:0]       ext_o,
    output logic                acc_vld_o,
    output logic                ovf_o
);
    localparam int unsigned PW = 2 * DW;
    localparam int unsigned AW = PW + GW;

    logic          s1_vld;
    logic [PW-1:0] s1_prod;
    logic          s1_sub;
    logic          s1_sat;
    logic [AW-1:0] acc_full;

    mac_mul_stage #(.DW(DW)) u_mul (
        .clk    (clk),
        .rst    (rst),
        .vld_i  (in_vld),
        .a_i    (op_a),
        .b_i    (op_b),
        .sub_i  (sub_sel),
        .sat_i  (sat_en),
        .vld_o  (s1_vld),
        .prod_o (s1_prod),
        .sub_o  (s1_sub),
        .sat_o  (s1_sat)
    );

    mac_acc_stage #(.DW(DW), .GW(GW)) u_acc (
        .clk    (clk),
        .rst    (rst),
        .upd_i  (s1_vld),
        .sub_i  (s1_sub),
        .sat_i  (s1_sat),
        .clr_i  (clr),
        .prod_i (s1_prod),
        .acc_o  (acc_full),
        .upd_o  (acc_vld_o),
        .ovf_o  (ovf_o)
    );

    mac_out_stage #(.DW(DW), .GW(GW)) u_out (
        .hi_i   (acc_full[AW-1:DW-2]),
        .rnd_i  (rnd_en),
        .res_o  (res_o)
    );

    assign acc_o = acc_full[PW-1:0];
    assign ext_o = acc_full[AW-1:PW];

    // R9: a non-negative accumulator never yields a negative result
    p_res_sign_r9: assert property (@(posedge clk) disable iff (rst)
        !acc_full[AW-1] |-> !res_o[DW-1]);

    // R11: a negative accumulator never yields a positive result
    p_res_neg_r11: assert property (@(posedge clk) disable iff (rst)
        acc_full[AW-1] |-> (res_o[DW-1] || res_o == '0));

endmodule

// File: tb/mac_sat_unit_bench.sv
`timescale 1ns/1ps
module mac_sat_unit_bench;
    localparam int unsigned DW = 16;
    localparam int unsigned GW = 8;
    localparam int unsigned PW = 2 * DW;

    typedef struct packed {
        logic signed [DW-1:0] a;
        logic signed [DW-1:0] b;
        logic                 sub;
        logic signed [PW-1:0] p;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{ 16'sd3,      16'sd5,      1'b0,  32'sd15         },
        '{ -16'sd4,     16'sd7,      1'b0,  -32'sd28        },
        '{ -16'sd32768, -16'sd32768, 1'b0,  32'sd1073741824 },
        '{ 16'sd32767,  -16'sd32768, 1'b1,  32'sd1073709056 },
        '{ 16'sd1234,   -16'sd1,     1'b1,  32'sd1234       },
        '{ -16'sd32768, 16'sd32767,  1'b0, -32'sd1073709056 },
        '{ 16'sd0,      16'sd999,    1'b0,  32'sd0          },
        '{ 16'sd100,    16'sd200,    1'b1,  -32'sd20000     }
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_vld = 1'b0;
    logic [DW-1:0] op_a = '0;
    logic [DW-1:0] op_b = '0;
    logic sub_sel = 1'b0;
    logic sat_en = 1'b0;
    logic clr = 1'b0;
    logic rnd_en = 1'b0;
    logic [DW-1:0] res_o;
    logic [PW-1:0] acc_o;
    logic [GW-1:0] ext_o;
    logic acc_vld_o;
    logic ovf_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    mac_sat_unit #(.DW(DW), .GW(GW)) u_mac_sat_unit (
        .clk(clk), .rst(rst), .in_vld(in_vld), .op_a(op_a), .op_b(op_b),
        .sub_sel(sub_sel), .sat_en(sat_en), .clr(clr), .rnd_en(rnd_en),
        .res_o(res_o), .acc_o(acc_o), .ext_o(ext_o),
        .acc_vld_o(acc_vld_o), .ovf_o(ovf_o)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint acc_val();
        logic signed [PW+GW-1:0] v;
        v = $signed({ext_o, acc_o});
        return longint'(v);
    endfunction

    // Result expected from R9, R10, R11 with DW=16.
    function automatic longint exp_res(input longint v, input bit rnd);
        longint lim;
        longint s;
        lim = longint'(1) <<< 30;
        if (v >= lim) return 32'h7FFF;
        if (v < -lim) return 32'h8000;
        s = v >>> 15;
        if (rnd && (((v >>> 14) & 1) == 1) && s != 32767) s = s + 1;
        return s & 32'hFFFF;
    endfunction

    // All tasks start and end at a falling edge.
    task automatic do_clear();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic push(input int a, input int b, input bit sub, input bit sat);
        in_vld = 1'b1;
        op_a = DW'(a);
        op_b = DW'(b);
        sub_sel = sub;
        sat_en = sat;
        @(negedge clk);
        in_vld = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        longint sum;
        int start;
        int last;
        int nupd;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // Reset state (R3 values)
        chk("R3 reset acc", acc_val(), 0);
        chk("R3 reset ovf", ovf_o, 0);
        chk("R4 reset acc_vld", acc_vld_o, 0);
        chk("R9 reset res", res_o, 0);

        // Vector table: one product from a cleared accumulator (R1, R2, R9, R11)
        for (int i = 0; i < NV; i++) begin
            do_clear();
            push(VECS[i].a, VECS[i].b, VECS[i].sub, 1'b1);
            @(negedge clk);
            chk($sformatf("R1 R2 vec%0d acc", i), acc_val(), longint'(VECS[i].p));
            chk($sformatf("R4 vec%0d acc_vld", i), acc_vld_o, 1);
            rnd_en = 1'b0;
            #0.1;
            chk($sformatf("R9 R11 vec%0d res", i), res_o, exp_res(longint'(VECS[i].p), 1'b0));
            @(negedge clk);
            chk($sformatf("R2 vec%0d hold", i), acc_val(), longint'(VECS[i].p));
        end

        // R4: 256-term series, completion at first-valid cycle + 257
        do_clear();
        start = cyc;
        nupd = 0;
        last = 0;
        sum = 0;
        for (int k = 0; k < 256; k++) begin
            in_vld = 1'b1;
            op_a = DW'(k + 1);
            op_b = DW'(3);
            sub_sel = 1'b0;
            sat_en = 1'b1;
            sum += longint'(k + 1) * 3;
            @(negedge clk);
            if (acc_vld_o) begin nupd++; last = cyc; end
        end
        in_vld = 1'b0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (acc_vld_o) begin nupd++; last = cyc; end
        end
        chk("R4 series updates", nupd, 256);
        chk("R4 series completion cycles", last - start, 257);
        chk("R4 series sum", acc_val(), sum);

        // R5: guard bits absorb growth with saturation off
        do_clear();
        for (int k = 0; k < 4; k++) push(-32768, -32768, 1'b0, 1'b0);
        @(negedge clk);
        chk("R5 guard acc_o", acc_o, 0);
        chk("R5 guard ext_o", ext_o, 1);
        chk("R8 no flag without saturation", ovf_o, 0);
        rnd_en = 1'b0;
        #0.1;
        chk("R11 positive clamp of result", res_o, 32'h7FFF);

        // R6: positive saturation
        do_clear();
        push(-32768, -32768, 1'b0, 1'b1);
        push(-32768, -32768, 1'b0, 1'b1);
        @(negedge clk);
        chk("R6 pos clamp acc", acc_o, 32'h7FFFFFFF);
        chk("R6 pos clamp ext", ext_o, 0);
        chk("R8 flag set", ovf_o, 1);
        push(1, 1, 1'b1, 1'b1);
        @(negedge clk);
        chk("R2 sub after clamp", acc_o, 32'h7FFFFFFE);
        chk("R8 flag sticky", ovf_o, 1);
        do_clear();
        chk("R3 clear drops flag", ovf_o, 0);
        chk("R3 clear zeroes acc", acc_val(), 0);

        // R7: negative saturation
        for (int k = 0; k < 3; k++) push(-32768, -32768, 1'b1, 1'b1);
        @(negedge clk);
        chk("R7 neg clamp acc", acc_o, 32'h80000000);
        chk("R7 neg clamp ext", ext_o, 8'hFF);
        chk("R8 flag set negative", ovf_o, 1);
        #0.1;
        chk("R11 negative clamp of result", res_o, 32'h8000);

        // R10: rounding
        do_clear();
        push(1, 16384, 1'b0, 1'b1);
        @(negedge clk);
        rnd_en = 1'b0; #0.1;
        chk("R9 truncate half", res_o, 0);
        rnd_en = 1'b1; #0.1;
        chk("R10 round half up", res_o, 1);
        do_clear();
        push(1, 16384, 1'b1, 1'b1);
        @(negedge clk);
        rnd_en = 1'b0; #0.1;
        chk("R9 truncate negative", res_o, 32'hFFFF);
        rnd_en = 1'b1; #0.1;
        chk("R10 round negative to zero", res_o, 0);
        do_clear();
        push(32767, -32768, 1'b1, 1'b1);
        push(1, 16384, 1'b0, 1'b1);
        @(negedge clk);
        chk("R10 near-max acc", acc_val(), 64'h3FFFC000);
        rnd_en = 1'b1; #0.1;
        chk("R10 round holds at max", res_o, 32'h7FFF);
        rnd_en = 1'b0;

        // R3: clear discards a product arriving at stage two on the same edge
        do_clear();
        push(3, 5, 1'b0, 1'b1);
        @(negedge clk);
        chk("R3 preload", acc_val(), 15);
        in_vld = 1'b1; op_a = DW'(7); op_b = DW'(7); sub_sel = 1'b0;
        @(negedge clk);
        in_vld = 1'b0;
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        chk("R3 clear priority acc", acc_val(), 0);
        chk("R3 clear priority acc_vld", acc_vld_o, 0);
        @(negedge clk);
        chk("R3 discarded product stays out", acc_val(), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule